// File: doc/BRIEF.md
# SD Host Command and Interrupt Register Block

This block is the register front end that an SD host controller presents to a processor for issuing card commands. Software loads a 32-bit argument and then writes a 16-bit command word. Writing the command word is the trigger: the command and its argument are latched and presented on a request/response handshake toward the card side. When the card side answers, the block stores the 128-bit response in four readable words and records command completion in a normal status register. If no answer arrives within a fixed number of cycles, the block records a timeout error instead.

Each event passes two masks. A status-enable mask decides whether the event is recorded in a status bit. A signal-enable mask decides whether a recorded bit drives the interrupt line. Status bits are cleared by writing ones to them. A self-clearing software reset register can abort the command in flight, or it can return every register to its reset value.

Register access is a single-cycle word bus with byte enables. Read data is combinational from the address. Addresses whose low two bits are not zero hit nothing.

Top module: `sdh_cmd_front`

## Requirements
- R1: After reset, every readable register reads 0, and `card_req_o` and `irq_o` are low.
- R2: The argument is read/write at offset 0x008. The command word occupies bits 31:16 of offset 0x00C: index in command bits 13:8, flags in 7:0. A write with byte enable 2 or 3 set while no command is in flight is accepted. In the next cycle `card_req_o` is high, `card_cmd_o` shows the command and `card_arg_o` shows the argument.
- R3: Present state at 0x024 bit 0 (command inhibit) and `card_req_o` are high from the cycle after an accepted command write until the cycle after the response or timeout.
- R4: A command write while command inhibit is high is ignored. The command readback and `card_cmd_o` keep the in-flight command.
- R5: A response (`card_rsp_valid_i` while inhibited) is stored at 0x010..0x01C, with word k holding response bits 32k+31:32k. It sets normal status bit 0 (command complete).
- R6: An event sets its status bit only when the matching status-enable bit is 1. Normal enables are in bits 15:0 of 0x034 and error enables in bits 31:16.
- R7: Status at 0x030 holds normal status in bits 15:0 and error status in bits 31:16. Writing a 1 clears a bit, writing a 0 leaves it unchanged, and an event in the same cycle as the clear wins.
- R8: Normal status bit 15 reads as the OR of all error status bits and cannot be written.
- R9: With no response within TIMEOUT_CYC cycles after the launch edge, error status bit 0 is set and command inhibit is released. Command complete is not set.
- R10: A response delivered with `card_rsp_err_i` high sets error status bit 1 as well as command complete.
- R11: `irq_o` is high exactly when some status bit is set and its signal-enable bit at 0x038 (same layout as 0x034) is also 1.
- R12: The software reset byte at 0x02F (bits 31:24 of word 0x02C) reads back its written value for one cycle and then reads 0. When bit 1 is set, the in-flight command is aborted and the other registers are kept. When bit 0 is set, all registers return to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte enables |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| card_req_o | output | 1 | Command request held toward the card side |
| card_arg_o | output | 32 | Latched argument |
| card_cmd_o | output | 16 | Latched command word |
| card_rsp_valid_i | input | 1 | Response valid from the card side |
| card_rsp_err_i | input | 1 | Response carries an error |
| card_rsp_i | input | 128 | Response payload |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the cases where ordering matters.

- **Second command while busy.** A design that lets it through would show the new command on the card pins.
- **Clear and event in the same cycle.** If the clear were given priority, a completion would be silently lost.
- **Write to the summary bit 15.** A design that made bit 15 writable would let software hide pending errors.
- **Timeout boundary.** Inhibit is checked one cycle before and one cycle at the limit, so an off-by-one counter shows up.
- **Two reset strengths.** The bench confirms that the command-line reset keeps the mask registers, while the full reset clears them.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned RSP_WORDS = 4;

  localparam logic [REG_AW-1:0] OFF_ARG    = 8'h08;
  localparam logic [REG_AW-1:0] OFF_CMD    = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_RSP0   = 8'h10;
  localparam logic [REG_AW-1:0] OFF_PSTATE = 8'h24;
  localparam logic [REG_AW-1:0] OFF_SRST   = 8'h2C;
  localparam logic [REG_AW-1:0] OFF_STAT   = 8'h30;
  localparam logic [REG_AW-1:0] OFF_SEN    = 8'h34;
  localparam logic [REG_AW-1:0] OFF_SIG    = 8'h38;

  localparam int unsigned SRST_ALL = 0;
  localparam int unsigned SRST_CMD = 1;

  localparam int unsigned NORM_W = 15;  // bit 15 is the error summary
  localparam int unsigned ERR_W  = 16;
  localparam int unsigned EVT_CC  = 0;  // normal: command complete
  localparam int unsigned EVT_TMO = 0;  // error: response timeout
  localparam int unsigned EVT_RSP = 1;  // error: response error

  typedef struct packed {
    logic [15:0] err;
    logic [15:0] norm;
  } hw_pair_t;

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] m;
    m = be_mask(be);
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/sdh_cmd_engine.sv
module sdh_cmd_engine #(
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned RSP_W       = 128,
  localparam int unsigned CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             wipe_i,
  input  logic             launch_i,
  input  logic [15:0]      cmd_wr_i,
  input  logic [31:0]      arg_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_err_i,
  input  logic [RSP_W-1:0] rsp_i,
  output logic             busy_o,
  output logic [15:0]      cmd_o,
  output logic [31:0]      arg_o,
  output logic [RSP_W-1:0] rsp_o,
  output logic             done_o,
  output logic             rsp_err_o,
  output logic             timeout_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      cmd_q;
  logic [31:0]      arg_q;
  logic [RSP_W-1:0] rsp_q;
  logic             accept, got, tmo;

  assign accept = launch_i & ~busy_q & ~abort_i;
  assign got    = busy_q & rsp_valid_i & ~abort_i;
  assign tmo    = busy_q & ~rsp_valid_i & ~abort_i &
                  (cnt_q == CNT_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      arg_q  <= '0;
      rsp_q  <= '0;
    end else if (wipe_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      arg_q  <= '0;
      rsp_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      cmd_q  <= cmd_wr_i;
      arg_q  <= arg_i;
    end else if (got) begin
      busy_q <= 1'b0;
      rsp_q  <= rsp_i;
    end else if (tmo) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign cmd_o     = cmd_q;
  assign arg_o     = arg_q;
  assign rsp_o     = rsp_q;
  assign done_o    = got;
  assign rsp_err_o = got & rsp_err_i;
  assign timeout_o = tmo;

  // R2
  launch_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(launch_i));
  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && launch_i && !abort_i |=> $stable(cmd_q));
  // R9
  tmo_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !busy_q);
endmodule

// File: rtl/sdh_int_regs.sv
module sdh_int_regs
  import sdh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wipe_i,
  input  logic [NORM_W-1:0] norm_evt_i,
  input  logic [ERR_W-1:0]  err_evt_i,
  input  logic              wr_stat_i,
  input  logic              wr_sen_i,
  input  logic              wr_sig_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        be_i,
  output logic [31:0]       stat_o,
  output logic [31:0]       sen_o,
  output logic [31:0]       sig_o,
  output logic              irq_o
);
  hw_pair_t          sen_q, sig_q;
  logic [NORM_W-1:0] nstat_q;
  logic [ERR_W-1:0]  estat_q;
  logic [31:0]       clr_mask;

  assign clr_mask = wr_stat_i ? (wdata_i & be_mask(be_i)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sen_q <= '0;
      sig_q <= '0;
    end else if (wipe_i) begin
      sen_q <= '0;
      sig_q <= '0;
    end else begin
      if (wr_sen_i) sen_q <= be_merge(sen_q, wdata_i, be_i);
      if (wr_sig_i) sig_q <= be_merge(sig_q, wdata_i, be_i);
    end
  end

  // event set beats a same-cycle clear
  for (genvar gi = 0; gi < NORM_W; gi++) begin : g_norm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     nstat_q[gi] <= 1'b0;
      else if (wipe_i) nstat_q[gi] <= 1'b0;
      else nstat_q[gi] <= (norm_evt_i[gi] & sen_q.norm[gi]) |
                          (nstat_q[gi] & ~clr_mask[gi]);
    end
  end

  for (genvar gi = 0; gi < ERR_W; gi++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     estat_q[gi] <= 1'b0;
      else if (wipe_i) estat_q[gi] <= 1'b0;
      else estat_q[gi] <= (err_evt_i[gi] & sen_q.err[gi]) |
                          (estat_q[gi] & ~clr_mask[16+gi]);
    end
  end

  assign stat_o = {estat_q, |estat_q, nstat_q};
  assign sen_o  = sen_q;
  assign sig_o  = sig_q;
  assign irq_o  = (|(nstat_q & sig_q.norm[NORM_W-1:0])) | (|(estat_q & sig_q.err));

  // R6
  norm_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nstat_q[EVT_CC]) |-> $past(sen_q.norm[EVT_CC]));
  // R7
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat_i && clr_mask[EVT_CC] && !norm_evt_i[EVT_CC] |=> !nstat_q[EVT_CC]);
  // R9
  tmo_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(estat_q[EVT_TMO]) |-> $past(err_evt_i[EVT_TMO]));
endmodule

// File: rtl/sdh_cmd_front.sv
module sdh_cmd_front
  import sdh_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned RSP_W       = 32 * RSP_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic [3:0]        bus_be_i,
  output logic [31:0]       bus_rdata_o,
  output logic              card_req_o,
  output logic [31:0]       card_arg_o,
  output logic [15:0]       card_cmd_o,
  input  logic              card_rsp_valid_i,
  input  logic              card_rsp_err_i,
  input  logic [RSP_W-1:0]  card_rsp_i,
  output logic              irq_o
);
  logic             aligned, wr;
  logic [31:0]      arg_q;
  logic [7:0]       srst_q;
  logic             wipe, abort;
  logic             launch;
  logic [15:0]      cmd_cur, cmd_wr;
  logic             busy, done, rsp_err, tmo;
  logic [RSP_W-1:0] rsp;
  logic [31:0]      stat, sen, sig;
  logic [NORM_W-1:0] norm_evt;
  logic [ERR_W-1:0]  err_evt;

  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign wr      = bus_req_i & bus_we_i & aligned;
  assign wipe    = srst_q[SRST_ALL];
  assign abort   = srst_q[SRST_ALL] | srst_q[SRST_CMD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            arg_q <= '0;
    else if (wipe)                          arg_q <= '0;
    else if (wr && bus_addr_i == OFF_ARG)   arg_q <= be_merge(arg_q, bus_wdata_i, bus_be_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            srst_q <= '0;
    else if (srst_q != '0)  srst_q <= '0;
    else if (wr && bus_addr_i == OFF_SRST && bus_be_i[3])
      srst_q <= bus_wdata_i[31:24];
  end

  assign launch = wr && (bus_addr_i == OFF_CMD) && (bus_be_i[3] || bus_be_i[2]);
  assign cmd_wr = {bus_be_i[3] ? bus_wdata_i[31:24] : cmd_cur[15:8],
                   bus_be_i[2] ? bus_wdata_i[23:16] : cmd_cur[7:0]};

  sdh_cmd_engine #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .RSP_W       (RSP_W)
  ) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (abort),
    .wipe_i      (wipe),
    .launch_i    (launch),
    .cmd_wr_i    (cmd_wr),
    .arg_i       (arg_q),
    .rsp_valid_i (card_rsp_valid_i),
    .rsp_err_i   (card_rsp_err_i),
    .rsp_i       (card_rsp_i),
    .busy_o      (busy),
    .cmd_o       (cmd_cur),
    .arg_o       (card_arg_o),
    .rsp_o       (rsp),
    .done_o      (done),
    .rsp_err_o   (rsp_err),
    .timeout_o   (tmo)
  );

  always_comb begin
    norm_evt          = '0;
    norm_evt[EVT_CC]  = done;
    err_evt           = '0;
    err_evt[EVT_TMO]  = tmo;
    err_evt[EVT_RSP]  = rsp_err;
  end

  sdh_int_regs u_int (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wipe_i     (wipe),
    .norm_evt_i (norm_evt),
    .err_evt_i  (err_evt),
    .wr_stat_i  (wr && bus_addr_i == OFF_STAT),
    .wr_sen_i   (wr && bus_addr_i == OFF_SEN),
    .wr_sig_i   (wr && bus_addr_i == OFF_SIG),
    .wdata_i    (bus_wdata_i),
    .be_i       (bus_be_i),
    .stat_o     (stat),
    .sen_o      (sen),
    .sig_o      (sig),
    .irq_o      (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (aligned) begin
      unique case (bus_addr_i)
        OFF_ARG:    bus_rdata_o = arg_q;
        OFF_CMD:    bus_rdata_o = {cmd_cur, 16'h0000};
        OFF_PSTATE: bus_rdata_o = {31'b0, busy};
        OFF_SRST:   bus_rdata_o = {srst_q, 24'h0};
        OFF_STAT:   bus_rdata_o = stat;
        OFF_SEN:    bus_rdata_o = sen;
        OFF_SIG:    bus_rdata_o = sig;
        default:    bus_rdata_o = '0;
      endcase
      for (int k = 0; k < RSP_WORDS; k++)
        if (bus_addr_i == OFF_RSP0 + REG_AW'(4 * k)) bus_rdata_o = rsp[32*k +: 32];
    end
  end

  assign card_req_o = busy;
  assign card_cmd_o = cmd_cur;

  // R12
  srst_self_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q != '0 |=> srst_q == '0);
  // R3
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_req_o) |-> $past(card_rsp_valid_i) || $past(tmo) || $past(abort));
endmodule

// File: tb/sdh_cmd_front_tb.sv
module sdh_cmd_front_tb;
  localparam int unsigned TMO = 20;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [7:0]   bus_addr_i = '0;
  logic [31:0]  bus_wdata_i = '0;
  logic [3:0]   bus_be_i = '0;
  logic [31:0]  bus_rdata_o;
  logic         card_req_o;
  logic [31:0]  card_arg_o;
  logic [15:0]  card_cmd_o;
  logic         card_rsp_valid_i = 1'b0, card_rsp_err_i = 1'b0;
  logic [127:0] card_rsp_i = '0;
  logic         irq_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rd;

  always #5 clk_i = ~clk_i;

  sdh_cmd_front #(.TIMEOUT_CYC(TMO)) u_dut (.*);

  typedef struct packed {
    logic [31:0] arg;
    logic [15:0] cmd;
    logic [31:0] w0;
    logic [31:0] w3;
    logic        err;
    logic        en;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h0000_1234, 16'h1100, 32'hCAFE_0001, 32'h0000_0900, 1'b0, 1'b1},
    '{32'hFFFF_FFFF, 16'h1805, 32'h1234_5678, 32'h8765_4321, 1'b1, 1'b1},
    '{32'h8000_0001, 16'h0D1A, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0, 1'b0},
    '{32'h5A5A_A5A5, 16'h3F00, 32'hDEAD_BEEF, 32'h0000_0001, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; bus_be_i = be;
    @(negedge clk_i);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a);
    bus_addr_i = a;
    #1;
    rd = bus_rdata_o;
  endtask

  task automatic respond(input logic [127:0] r, input logic e);
    @(negedge clk_i);
    card_rsp_valid_i = 1'b1; card_rsp_i = r; card_rsp_err_i = e;
    @(negedge clk_i);
    card_rsp_valid_i = 1'b0; card_rsp_err_i = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rdreg(8'h08); chk("R1 arg", rd, 0);
    rdreg(8'h30); chk("R1 stat", rd, 0);
    rdreg(8'h24); chk("R1 pstate", rd, 0);
    rdreg(8'h34); chk("R1 sen", rd, 0);
    chk("R1 req", {31'b0, card_req_o}, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);

    foreach (VECS[i]) begin
      vec_t v;
      logic [15:0] e_exp, n_exp;
      v = VECS[i];
      wr(8'h34, v.en ? 32'hFFFF_FFFF : 32'h0, 4'hF);
      wr(8'h08, v.arg, 4'hF);
      rdreg(8'h08); chk("R2 arg readback", rd, v.arg);
      wr(8'h0C, {v.cmd, 16'h0}, 4'b1100);
      chk("R2 req", {31'b0, card_req_o}, 1);
      chk("R2 card_arg", card_arg_o, v.arg);
      chk("R2 card_cmd", {16'h0, card_cmd_o}, {16'h0, v.cmd});
      rdreg(8'h24); chk("R3 inhibit high", rd, 1);
      @(negedge clk_i);
      respond({v.w3, ~v.w0, v.w3 ^ v.w0, v.w0}, v.err);
      rdreg(8'h24); chk("R3 inhibit low", rd, 0);
      chk("R3 req low", {31'b0, card_req_o}, 0);
      rdreg(8'h10); chk("R5 rsp0", rd, v.w0);
      rdreg(8'h14); chk("R5 rsp1", rd, v.w3 ^ v.w0);
      rdreg(8'h18); chk("R5 rsp2", rd, ~v.w0);
      rdreg(8'h1C); chk("R5 rsp3", rd, v.w3);
      e_exp = {14'b0, v.err & v.en, 1'b0};
      n_exp = {|e_exp, 14'b0, v.en};
      rdreg(8'h30); chk("R6 R10 R8 status", rd, {e_exp, n_exp});
      wr(8'h30, 32'hFFFF_FFFF, 4'hF);
      rdreg(8'h30); chk("R7 clear all", rd, 0);
    end

    // R4 command while busy ignored
    wr(8'h34, 32'hFFFF_FFFF, 4'hF);
    wr(8'h0C, 32'h1100_0000, 4'b1100);
    wr(8'h0C, 32'h2A33_0000, 4'b1100);
    rdreg(8'h0C); chk("R4 cmd readback", rd, 32'h1100_0000);
    chk("R4 card_cmd", {16'h0, card_cmd_o}, 32'h0000_1100);
    respond(128'h0, 1'b1);
    // R7 partial clear, R8 summary bit
    rdreg(8'h30); chk("R10 status", rd, 32'h0002_8001);
    wr(8'h30, 32'h0000_0001, 4'hF);
    rdreg(8'h30); chk("R7 partial clear", rd, 32'h0002_8000);
    wr(8'h30, 32'h0000_8000, 4'hF);
    rdreg(8'h30); chk("R8 bit15 read-only", rd, 32'h0002_8000);
    // R11 interrupt masking
    chk("R11 no sig", {31'b0, irq_o}, 0);
    wr(8'h38, 32'h0000_0001, 4'hF);
    chk("R11 wrong sig", {31'b0, irq_o}, 0);
    wr(8'h38, 32'h0002_0000, 4'hF);
    chk("R11 err sig", {31'b0, irq_o}, 1);
    wr(8'h30, 32'h0002_0000, 4'hF);
    chk("R11 cleared", {31'b0, irq_o}, 0);
    rdreg(8'h30); chk("R8 summary drops", rd, 0);

    // R7 same-cycle set beats clear
    wr(8'h0C, 32'h0500_0000, 4'b1100);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 8'h30;
    bus_wdata_i = 32'hFFFF_FFFF; bus_be_i = 4'hF;
    card_rsp_valid_i = 1'b1;
    @(negedge clk_i);
    bus_req_i = 1'b0; bus_we_i = 1'b0; card_rsp_valid_i = 1'b0;
    rdreg(8'h30); chk("R7 set wins", rd, 32'h0000_0001);
    wr(8'h30, 32'hFFFF_FFFF, 4'hF);

    // R9 timeout boundary
    wr(8'h0C, 32'h0800_0000, 4'b1100);
    repeat (TMO - 1) @(negedge clk_i);
    rdreg(8'h24); chk("R9 busy before limit", rd, 1);
    @(negedge clk_i);
    rdreg(8'h24); chk("R9 released at limit", rd, 0);
    rdreg(8'h30); chk("R9 timeout status", rd, 32'h0001_8000);
    wr(8'h30, 32'hFFFF_FFFF, 4'hF);

    // R12 command-line reset and full reset
    wr(8'h38, 32'h0000_0001, 4'hF);
    wr(8'h08, 32'hABCD_0000, 4'hF);
    wr(8'h0C, 32'h1100_0000, 4'b1100);
    wr(8'h2C, 32'h0200_0000, 4'b1000);
    rdreg(8'h2C); chk("R12 srst readback", rd, 32'h0200_0000);
    @(negedge clk_i);
    rdreg(8'h2C); chk("R12 srst self clear", rd, 0);
    rdreg(8'h24); chk("R12 cmd abort", rd, 0);
    rdreg(8'h34); chk("R12 cmd reset keeps sen", rd, 32'hFFFF_FFFF);
    rdreg(8'h30); chk("R12 no status on abort", rd, 0);
    wr(8'h2C, 32'h0100_0000, 4'b1000);
    @(negedge clk_i);
    rdreg(8'h34); chk("R12 full reset sen", rd, 0);
    rdreg(8'h38); chk("R12 full reset sig", rd, 0);
    rdreg(8'h08); chk("R12 full reset arg", rd, 0);
    rdreg(8'h0C); chk("R12 full reset cmd", rd, 0);

    summary();
  end
endmodule